// File: doc/BRIEF.md
# Buffered Configuration Port Controller

This peripheral sits between a host bus and a device configuration port. It owns a one-frame word buffer. The host fills the buffer or reads it back with plain word accesses. The host programs a byte length and a starting word offset. A single write to the direction register then starts a burst. A configure burst streams buffer words out to the port. A readback burst captures words from the port into the buffer.

A status register combines three things: a completion flag, four bits that always read as one, and the live flags reported by the configuration port. The host polls the completion flag to learn when the burst has finished. Writing any value to the status address aborts the transfer logic. The configuration port is modelled as a word stream. Outgoing words use a valid/ready handshake. Readback words arrive with a valid strobe while the controller holds a request line high.

Top module: `cfgport_bridge`

## Requirements
- R1: The buffer holds BUF_WORDS (default 512) 32-bit words. Word w is at bus byte address 4*w, and the whole buffer lies below byte address 0x800. A read strobe returns data on `bus_rdata` one clock later.
- R2: Address 0x800 holds the transfer length in bytes, with all 32 bits readable and writable. Address 0x804 holds the starting word offset, kept in its low 9 bits; the upper bits read as zero.
- R3: A write to 0x808 starts a transfer. Data bit 0 = 1 selects readback and 0 selects configure. The transfer moves ceil(length/4) words, so a length that is not a multiple of 4 is rounded up to a whole word. Reads of 0x808 return zero.
- R4: During a configure transfer, `cp_wvalid` is high while words remain, and `cp_wdata` equals the buffer word at the current pointer. The pointer advances by one on each cycle with `cp_wvalid && cp_wready`. At most one word moves per cycle.
- R5: During a readback transfer, `cp_rd_req` is high while words remain. Each cycle with `cp_rvalid` stores `cp_rdata` at the current pointer and advances it by one.
- R6: Status at 0x80C is laid out as follows. Bit 0 is done: 1 when idle, and 0 from the clock edge that accepts the start write until the edge that moves the last word. Bits 4..1 read 1111. Bit 5 is `cp_abort_n`, bit 6 is `cp_rip`, bit 7 is `cp_dalign`, and bit 8 is `cp_cfgerr`. Bits 31..9 read zero.
- R7: A start with a length of zero moves no word, and the done bit stays 1.
- R8: Buffer addressing wraps modulo 512 words when offset plus length passes the end of the buffer.
- R9: A write to 0x808 while a transfer is in progress is ignored. The running transfer keeps its direction and its remaining count.
- R10: A write of any value to 0x80C ends a running transfer at once. Done reads 1 afterwards, and the port request lines drop.
- R11: Host writes to the buffer while a transfer is in progress are ignored, and the buffer keeps its old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Host write strobe |
| bus_re | input | 1 | Host read strobe |
| bus_addr | input | 12 | Host byte address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, valid one cycle after `bus_re` |
| cp_wdata | output | 32 | Configure word to the port |
| cp_wvalid | output | 1 | Configure word valid |
| cp_wready | input | 1 | Port accepts configure word |
| cp_rd_req | output | 1 | Readback words requested |
| cp_rdata | input | 32 | Readback word from the port |
| cp_rvalid | input | 1 | Readback word strobe |
| cp_abort_n | input | 1 | Port abort flag, active low |
| cp_rip | input | 1 | Port readback-in-progress flag |
| cp_dalign | input | 1 | Port data-aligned flag |
| cp_cfgerr | input | 1 | Port configuration error flag |

## Verification
The bench builds the block with its default parameters: 512 words of 32 bits and a 12-bit byte address. With these values the register block sits at 0x800. An offset near word 511 then crosses the end of the buffer in a few words, so wrap-around in both directions is reachable in short bursts. The ready and valid strobes from the port follow fixed irregular patterns, so every burst contains stall cycles. Registers are also written in the same cycles as transfer activity, which exercises abort, ignored restarts and ignored buffer writes against a running model.

// File: rtl/cfgport_bridge.sv
module cfgport_bridge #(
  parameter int BUF_WORDS = 512,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = $clog2(BUF_WORDS * 4) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] cp_wdata,
  output logic              cp_wvalid,
  input  logic              cp_wready,
  output logic              cp_rd_req,
  input  logic [DATA_W-1:0] cp_rdata,
  input  logic              cp_rvalid,
  input  logic              cp_abort_n,
  input  logic              cp_rip,
  input  logic              cp_dalign,
  input  logic              cp_cfgerr
);
  localparam int IDX_W = $clog2(BUF_WORDS);
  localparam logic [1:0] SEL_SIZE = 2'd0;
  localparam logic [1:0] SEL_OFFS = 2'd1;
  localparam logic [1:0] SEL_DIR  = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  logic [DATA_W-1:0] mem [BUF_WORDS];
  logic [DATA_W-1:0] size_q;
  logic [IDX_W-1:0]  off_q, ptr_q;
  logic [DATA_W-2:0] rem_q;
  logic              dir_q;

  wire              busy      = rem_q != '0;
  wire              reg_space = bus_addr[ADDR_W-1];
  wire [1:0]        reg_sel   = bus_addr[3:2];
  wire [IDX_W-1:0]  word_idx  = bus_addr[IDX_W+1:2];
  wire              unused_lsb = ^bus_addr[1:0];

  wire wr_buf  = bus_we & ~reg_space & ~busy;
  wire wr_size = bus_we & reg_space & (reg_sel == SEL_SIZE);
  wire wr_offs = bus_we & reg_space & (reg_sel == SEL_OFFS);
  wire wr_dir  = bus_we & reg_space & (reg_sel == SEL_DIR);
  wire wr_stat = bus_we & reg_space & (reg_sel == SEL_STAT);

  wire [DATA_W-2:0] words_req = {1'b0, size_q[DATA_W-1:2]}
                              + {{(DATA_W-2){1'b0}}, |size_q[1:0]};

  assign cp_wvalid = busy & ~dir_q;
  assign cp_rd_req = busy & dir_q;
  assign cp_wdata  = mem[ptr_q];

  wire mv_in = cp_rd_req & cp_rvalid;
  wire step  = (cp_wvalid & cp_wready) | mv_in;

  wire [DATA_W-1:0] status = {{(DATA_W-9){1'b0}}, cp_cfgerr, cp_dalign,
                              cp_rip, cp_abort_n, 4'hF, ~busy};

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q <= '0;
      off_q  <= '0;
      ptr_q  <= '0;
      rem_q  <= '0;
      dir_q  <= 1'b0;
    end else begin
      if (wr_size) size_q <= bus_wdata;
      if (wr_offs) off_q  <= bus_wdata[IDX_W-1:0];
      if (wr_stat) begin
        rem_q <= '0;
      end else if (wr_dir && !busy) begin
        dir_q <= bus_wdata[0];
        ptr_q <= off_q;
        rem_q <= words_req;
      end else if (step) begin
        ptr_q <= ptr_q + IDX_W'(1);
        rem_q <= rem_q - {{(DATA_W-2){1'b0}}, 1'b1};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (mv_in)       mem[ptr_q]    <= cp_rdata;
    else if (wr_buf) mem[word_idx] <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      if (!reg_space) bus_rdata <= mem[word_idx];
      else begin
        case (reg_sel)
          SEL_SIZE: bus_rdata <= size_q;
          SEL_OFFS: bus_rdata <= {{(DATA_W-IDX_W){1'b0}}, off_q};
          SEL_DIR:  bus_rdata <= '0;
          default:  bus_rdata <= status;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfgport_bridge_chk.sv
module cfgport_bridge_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic              bus_re,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] cp_wdata,
  input logic              cp_wvalid,
  input logic              cp_wready,
  input logic              cp_rd_req
);
  wire stat_hit = bus_addr[ADDR_W-1] && (bus_addr[3:2] == 2'd3);
  wire dir_hit  = bus_addr[ADDR_W-1] && (bus_addr[3:2] == 2'd2);

  // R4
  dir_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(cp_wvalid && cp_rd_req));

  // R4
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cp_wvalid && !cp_wready && !(bus_we && stat_hit) |=> cp_wvalid && $stable(cp_wdata));

  // R10
  abort_drop_chk: assert property (@(posedge clk) disable iff (rst)
    bus_we && stat_hit |=> !cp_wvalid && !cp_rd_req);

  // R9
  restart_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    cp_wvalid && bus_we && dir_hit && !stat_hit |=> !cp_rd_req);

  // R6
  stat_ones_chk: assert property (@(posedge clk) disable iff (rst)
    bus_re && stat_hit |=> bus_rdata[4:1] == 4'hF);

  // R6
  busy_done_chk: assert property (@(posedge clk) disable iff (rst)
    bus_re && stat_hit && (cp_wvalid || cp_rd_req) |=> !bus_rdata[0]);
endmodule

bind cfgport_bridge cfgport_bridge_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .cp_wdata(cp_wdata), .cp_wvalid(cp_wvalid),
  .cp_wready(cp_wready), .cp_rd_req(cp_rd_req)
);

// File: tb/cfgport_bridge_tb.sv
`timescale 1ns/1ps
module cfgport_bridge_tb;
  logic clk = 0, rst = 1;
  logic bus_we = 0, bus_re = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, cp_wdata, cp_rdata = '0;
  logic cp_wvalid, cp_wready = 0, cp_rd_req, cp_rvalid = 0;
  logic cp_abort_n = 1, cp_rip = 0, cp_dalign = 0, cp_cfgerr = 0;

  cfgport_bridge u_dut (.*);

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0, nout = 0, cyc = 0;
  bit rdy_en = 0, rv_en = 0, running = 0, ended = 0;

  logic [31:0] m_mem [512];
  logic [31:0] m_size;
  int unsigned m_rem, m_ptr, m_off;
  bit m_dir;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] stat_exp(input bit done);
    return {23'd0, cp_cfgerr, cp_dalign, cp_rip, cp_abort_n, 4'hF, done};
  endfunction

  initial for (int i = 0; i < 512; i++) m_mem[i] = '0;

  // behavioural reference, updated from the stimulus only
  always @(posedge clk) begin
    if (rst) begin
      m_rem = 0; m_ptr = 0; m_off = 0; m_size = 0; m_dir = 0;
    end else begin
      bit mv, idle;
      int unsigned a, words;
      idle = (m_rem == 0);
      mv = !idle && (m_dir ? cp_rvalid : cp_wready);
      words = (m_size + 3) / 4;
      if (m_size > 32'hFFFFFFFC) words = 32'h40000000;
      a = bus_addr;
      if (mv && m_dir) m_mem[m_ptr] = cp_rdata;
      if (bus_we && a < 'h800 && idle) m_mem[a / 4] = bus_wdata;
      if (bus_we && a == 'h800) m_size = bus_wdata;
      if (bus_we && a == 'h804) m_off = bus_wdata % 512;
      if (bus_we && a == 'h80C) m_rem = 0;
      else if (bus_we && a == 'h808 && idle) begin
        m_dir = bus_wdata[0]; m_ptr = m_off; m_rem = words;
      end else if (mv) begin
        m_ptr = (m_ptr + 1) % 512; m_rem = m_rem - 1;
      end
      if (cp_wvalid && cp_wready) nout++;
    end
  end

  always @(negedge clk) begin
    cyc++;
    cp_wready = rdy_en && (cyc % 3 != 1);
    cp_rvalid = rv_en && cyc[0];
    cp_rdata  = 32'hC0DE0000 ^ cyc;
    if (running) begin
      bit ev;
      ev = (m_rem != 0) && !m_dir;
      chk(cp_wvalid === ev && (!ev || cp_wdata === m_mem[m_ptr]), "R4 stream",
          {cp_wvalid, cp_wdata[30:0]}, {ev, m_mem[m_ptr][30:0]});
      chk(cp_rd_req === ((m_rem != 0) && m_dir), "R5 request", cp_rd_req, (m_rem != 0) && m_dir);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_re = 1; bus_addr = a;
    @(negedge clk); bus_re = 0; d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 400; i++) begin
      rd(12'h80C, s);
      if (s[0]) break;
    end
  endtask

  task automatic start(input int sz, input int off, input bit dir);
    wr(12'h800, sz); wr(12'h804, off); wr(12'h808, {31'd0, dir});
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(5 * 150000);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int n0;
    repeat (4) @(negedge clk);
    rst = 0;
    running = 1;
    rd(12'h80C, d); chk(d === 32'h3F, "R6 reset status", d, 32'h3F);

    for (int i = 0; i < 8; i++) wr(12'(i * 4), 32'hA0000000 + i * 17);
    wr(12'h7F8, 32'h51051051); wr(12'h7FC, 32'h51151151);
    rd(12'h00C, d); chk(d === 32'hA0000033, "R1 word 3", d, 32'hA0000033);
    rd(12'h7FC, d); chk(d === 32'h51151151, "R1 word 511", d, 32'h51151151);

    wr(12'h800, 32'hDEADBEE1); rd(12'h800, d); chk(d === 32'hDEADBEE1, "R2 size", d, 32'hDEADBEE1);
    wr(12'h804, 32'hFFFFFE05); rd(12'h804, d); chk(d === 32'h5, "R2 offset mask", d, 32'h5);
    rd(12'h808, d); chk(d === 0, "R3 direction reads zero", d, 0);

    rdy_en = 1; n0 = nout;
    start(20, 2, 0);
    rd(12'h80C, d); chk(d === stat_exp(0), "R6 busy", d, stat_exp(0));
    wait_idle(); chk(nout - n0 == 5, "R3 R4 five words", nout - n0, 5);

    n0 = nout; start(6, 0, 0); wait_idle();
    chk(nout - n0 == 2, "R3 rounding", nout - n0, 2);

    n0 = nout; start(0, 0, 0);
    rd(12'h80C, d); chk(d === stat_exp(1), "R7 zero done", d, stat_exp(1));
    chk(nout == n0, "R7 no words", nout - n0, 0);

    n0 = nout; start(16, 510, 0); wait_idle();
    chk(nout - n0 == 4, "R8 configure wrap", nout - n0, 4);

    rdy_en = 0; rv_en = 1;
    start(12, 100, 1); wait_idle(); rv_en = 0;
    for (int i = 100; i < 103; i++) begin
      rd(12'(i * 4), d); chk(d === m_mem[i], "R5 readback word", d, m_mem[i]);
    end
    rv_en = 1; start(8, 511, 1); wait_idle(); rv_en = 0;
    rd(12'h000, d); chk(d === m_mem[0] && d[31:16] == 16'hC0DE, "R8 readback wrap", d, m_mem[0]);

    start(8, 0, 0);
    wr(12'h808, 1);
    @(negedge clk); chk(cp_wvalid && !cp_rd_req, "R9 restart ignored", {cp_wvalid, cp_rd_req}, 2'b10);
    n0 = nout; rdy_en = 1; wait_idle(); rdy_en = 0;
    chk(nout - n0 == 2, "R9 count kept", nout - n0, 2);

    start(40, 0, 0);
    repeat (2) @(negedge clk);
    wr(12'h80C, 32'h1234);
    rd(12'h80C, d); chk(d === stat_exp(1), "R10 abort done", d, stat_exp(1));
    chk(!cp_wvalid, "R10 stream dropped", cp_wvalid, 0);

    start(4, 3, 0);
    wr(12'h01C, 32'h55);
    wr(12'h80C, 0);
    rd(12'h01C, d); chk(d === 32'hA0000077, "R11 buffer unchanged", d, 32'hA0000077);

    cp_cfgerr = 1; cp_dalign = 1; cp_abort_n = 0;
    rd(12'h80C, d); chk(d === 32'h19F, "R6 port flags", d, 32'h19F);
    cp_rip = 1; cp_cfgerr = 0;
    rd(12'h80C, d); chk(d === 32'hDF, "R6 rip flag", d, 32'hDF);

    running = 0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule